// File: doc/BRIEF.md
# I2C Programmable Bit Timing Engine

This block turns single bus primitives into the SCL and SDA waveforms of one I2C master, clocked from a fast system clock. A controller above it issues one primitive at a time: START, repeated START, STOP, write bit or read bit. It waits for a one-cycle completion pulse. For a read bit it then takes the sampled bit. Byte framing, addressing, buffering and arbitration handling belong to other blocks.

Every bus phase has its own count, held in three 32-bit timing words per speed set plus one shared hold word. The engine keeps two complete sets, one for standard/fast mode and one for high-speed mode. The mode input selects a set when a primitive is accepted. A shared prescaler stretches each count unit to (prescaler+1) system clocks. The pads are open-drain: an enable of 1 pulls the line low. SCL is read back, and any phase that begins by releasing SCL waits while another device keeps SCL low.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both pull-down enables are 0, `cmd_ready` is 1, `done` is 0 and `rx_bit` is 0.
- R2: A timing unit lasts P+1 clocks, where P is bits 23:16 of the third timing word. A phase with count N lasts max(N,1) units, and the unit counter restarts at every phase boundary.
- R3: START (op 0) releases both lines for start-setup units (word 1 bits 31:24). It then pulls SDA low for start-hold units (word 1 bits 23:16). It then pulls SCL low and completes.
- R4: Repeated START (op 1) releases SDA while SCL stays low for release units (word 3 bits 7:0). It then runs the START sequence of R3.
- R5: Write bit (op 3) keeps SDA unchanged for hold units (shared word bits 7:0). It then drives SDA to `cmd_bit` (enable = not bit) for SCL-low units (word 2 bits 15:8). It then releases SCL for the high phase of R6, pulls SCL low and completes with SDA unchanged.
- R6: Read bit (op 4) has the same timing as R5 with SDA released. The high phase is split into floor(H/2) units and then H-floor(H/2) units, each at least one unit, where H is word 2 bits 7:0. `rx_bit` takes SDA at the end of the first part and holds it.
- R7: STOP (op 2) keeps SDA unchanged for hold units. It then pulls SDA low for data-setup units (word 2 bits 31:24). It then releases SCL for stop-setup units (word 1 bits 15:8). It then releases SDA and completes with both lines released.
- R8: A phase that begins by releasing SCL (start setup, first high part, stop setup) does not count while `scl_in` reads low. Each clock of stretching extends that phase by one clock.
- R9: `hs_mode` at acceptance selects the high-speed words (1) or the standard/fast words (0) for the whole primitive. Later changes of `hs_mode` have no effect until the next primitive.
- R10: `done` is a single-cycle pulse on the edge where the primitive ends, which is also the edge where `cmd_ready` returns to 1. While busy, `cmd_ready` is 0 and `cmd_valid` is ignored.
- R11: An op code of 5, 6 or 7 is ignored. The engine stays ready and both lines keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | Timing set select, taken when a primitive is accepted |
| fs_tim1 | input | 32 | Standard/fast word 1: start setup, start hold, stop setup |
| fs_tim2 | input | 32 | Standard/fast word 2: data setup, SCL low, SCL high |
| fs_tim3 | input | 32 | Standard/fast word 3: prescaler, repeated-start release |
| hs_tim1 | input | 32 | High-speed word 1 |
| hs_tim2 | input | 32 | High-speed word 2 |
| hs_tim3 | input | 32 | High-speed word 3 |
| hold_tim | input | 32 | Shared data-hold count in bits 7:0 |
| cmd_valid | input | 1 | Primitive request, taken when `cmd_ready` is 1 |
| cmd_op | input | 3 | 0 START, 1 repeated START, 2 STOP, 3 write bit, 4 read bit |
| cmd_bit | input | 1 | Value for a write bit |
| cmd_ready | output | 1 | Engine idle |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last bit sampled by a read |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the timing words and the prescaler stay constant while a primitive runs. They also assume that `scl_in` and `sda_in` are already synchronous to `clk`, and that a stretching device only keeps SCL low around the moment the engine releases it. The stimulus changes timing words only while the engine is idle. It models the bus as a wired-AND of the engine's enables and a device that holds SCL low for a chosen number of clocks after a release. It sets the device's SDA before a primitive starts and keeps it fixed until the primitive ends.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    parameter int unsigned FIELD_W = 8;
    parameter int unsigned WORD_W  = 32;

    // bit positions inside the timing words
    localparam int unsigned W1_SSU_LSB = 24;
    localparam int unsigned W1_SHD_LSB = 16;
    localparam int unsigned W1_SSP_LSB = 8;
    localparam int unsigned W2_DSU_LSB = 24;
    localparam int unsigned W2_LO_LSB  = 8;
    localparam int unsigned W2_HI_LSB  = 0;
    localparam int unsigned W3_PRE_LSB = 16;
    localparam int unsigned W3_REL_LSB = 0;
    localparam int unsigned HD_LSB     = 0;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_STOP   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SU, S_HD, S_REL, S_BHOLD, S_BLOW,
        S_HIA, S_HIB, S_PHOLD, S_PLOW, S_PSU
    } st_e;

    typedef struct packed {
        logic [FIELD_W-1:0] start_su;
        logic [FIELD_W-1:0] start_hd;
        logic [FIELD_W-1:0] stop_su;
        logic [FIELD_W-1:0] data_su;
        logic [FIELD_W-1:0] scl_lo;
        logic [FIELD_W-1:0] scl_hi;
        logic [FIELD_W-1:0] presc;
        logic [FIELD_W-1:0] sr_rel;
        logic [FIELD_W-1:0] data_hd;
    } tset_t;

    typedef struct packed {
        st_e                st;
        logic [FIELD_W-1:0] ucnt;
        logic               scl;
        logic               sda;
        logic               done;
        logic               rx;
        logic               hs;
        logic               rd;
        logic               wbit;
    } seq_regs_t;

    function automatic st_e next_phase(st_e s);
        case (s)
            S_SU:    return S_HD;
            S_REL:   return S_SU;
            S_BHOLD: return S_BLOW;
            S_BLOW:  return S_HIA;
            S_HIA:   return S_HIB;
            S_PHOLD: return S_PLOW;
            S_PLOW:  return S_PSU;
            default: return S_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bt_setsel.sv
module i2c_bt_setsel
    import i2c_bt_pkg::*;
#(
    parameter int unsigned NSETS = 2
) (
    input  logic              sel_hs,
    input  logic [WORD_W-1:0] fs_w1,
    input  logic [WORD_W-1:0] fs_w2,
    input  logic [WORD_W-1:0] fs_w3,
    input  logic [WORD_W-1:0] hs_w1,
    input  logic [WORD_W-1:0] hs_w2,
    input  logic [WORD_W-1:0] hs_w3,
    input  logic [WORD_W-1:0] hold_w,
    output tset_t             tim
);

    logic [WORD_W-1:0] w1 [NSETS];
    logic [WORD_W-1:0] w2 [NSETS];
    logic [WORD_W-1:0] w3 [NSETS];
    tset_t             dec [NSETS];

    assign w1[0] = fs_w1;
    assign w2[0] = fs_w2;
    assign w3[0] = fs_w3;
    assign w1[1] = hs_w1;
    assign w2[1] = hs_w2;
    assign w3[1] = hs_w3;

    for (genvar g = 0; g < NSETS; g++) begin : g_dec
        assign dec[g].start_su = w1[g][W1_SSU_LSB +: FIELD_W];
        assign dec[g].start_hd = w1[g][W1_SHD_LSB +: FIELD_W];
        assign dec[g].stop_su  = w1[g][W1_SSP_LSB +: FIELD_W];
        assign dec[g].data_su  = w2[g][W2_DSU_LSB +: FIELD_W];
        assign dec[g].scl_lo   = w2[g][W2_LO_LSB  +: FIELD_W];
        assign dec[g].scl_hi   = w2[g][W2_HI_LSB  +: FIELD_W];
        assign dec[g].presc    = w3[g][W3_PRE_LSB +: FIELD_W];
        assign dec[g].sr_rel   = w3[g][W3_REL_LSB +: FIELD_W];
        assign dec[g].data_hd  = hold_w[HD_LSB +: FIELD_W];
    end

    assign tim = sel_hs ? dec[1] : dec[0];

    // reserved word bits carry no meaning here
    logic unused_bits;
    assign unused_bits = ^{fs_w1[7:0], fs_w2[23:16], fs_w3[31:24], fs_w3[15:8],
                           hs_w1[7:0], hs_w2[23:16], hs_w3[31:24], hs_w3[15:8],
                           hold_w[WORD_W-1:FIELD_W]};

endmodule

// File: rtl/i2c_bt_tick.sv
module i2c_bt_tick
    import i2c_bt_pkg::*;
#(
    parameter int unsigned PW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] presc,
    output logic          tick
);

    logic [PW-1:0] pcnt_d, pcnt_q;

    always_comb begin
        if (load || pcnt_q == '0) begin
            pcnt_d = presc;
        end else begin
            pcnt_d = pcnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

    assign tick = !load && (pcnt_q == '0);

    // R2: each unit counts down one clock at a time
    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && pcnt_q != '0) |=> (pcnt_q == $past(pcnt_q) - 1'b1));

    // R2: a unit boundary restarts the count at the prescaler value
    a_r2_unit_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == $past(presc)));

endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
    import i2c_bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tset_t      tim,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_bit,
    input  logic       cmd_hs,
    input  logic       tick,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       load,
    output logic       busy_hs,
    output logic       cmd_ready,
    output logic       done,
    output logic       rx_bit,
    output logic       scl_oe,
    output logic       sda_oe
);

    seq_regs_t r_d, r_q;
    logic      stall;
    logic      adv;
    logic      enter;
    st_e       tgt;

    assign stall = (r_q.st == S_SU || r_q.st == S_HIA || r_q.st == S_PSU) && !scl_in;
    assign adv   = tick && (r_q.ucnt <= 1);
    assign load  = (r_q.st == S_IDLE) || stall;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        enter    = 1'b0;
        tgt      = S_IDLE;

        if (r_q.st == S_IDLE) begin
            if (cmd_valid && cmd_op <= OP_READ) begin
                enter    = 1'b1;
                r_d.hs   = cmd_hs;
                r_d.rd   = (cmd_op == OP_READ);
                r_d.wbit = cmd_bit;
                case (cmd_op)
                    OP_START:  tgt = S_SU;
                    OP_RSTART: tgt = S_REL;
                    OP_STOP:   tgt = S_PHOLD;
                    default:   tgt = S_BHOLD;
                endcase
            end
        end else if (tick) begin
            if (adv) begin
                enter = 1'b1;
                tgt   = next_phase(r_q.st);
            end else begin
                r_d.ucnt = r_q.ucnt - 1'b1;
            end
        end

        if (r_q.st == S_HIA && adv && r_q.rd) begin
            r_d.rx = sda_in;
        end

        if (enter) begin
            case (tgt)
                S_SU: begin
                    r_d.scl  = 1'b0;
                    r_d.sda  = 1'b0;
                    r_d.ucnt = tim.start_su;
                end
                S_HD: begin
                    r_d.sda  = 1'b1;
                    r_d.ucnt = tim.start_hd;
                end
                S_REL: begin
                    r_d.sda  = 1'b0;
                    r_d.ucnt = tim.sr_rel;
                end
                S_BHOLD, S_PHOLD: begin
                    r_d.ucnt = tim.data_hd;
                end
                S_BLOW: begin
                    r_d.sda  = r_d.rd ? 1'b0 : !r_d.wbit;
                    r_d.ucnt = tim.scl_lo;
                end
                S_HIA: begin
                    r_d.scl  = 1'b0;
                    r_d.ucnt = tim.scl_hi >> 1;
                end
                S_HIB: begin
                    r_d.ucnt = tim.scl_hi - (tim.scl_hi >> 1);
                end
                S_PLOW: begin
                    r_d.sda  = 1'b1;
                    r_d.ucnt = tim.data_su;
                end
                S_PSU: begin
                    r_d.scl  = 1'b0;
                    r_d.ucnt = tim.stop_su;
                end
                default: begin
                    r_d.ucnt = '0;
                    r_d.done = 1'b1;
                    if (r_q.st == S_PSU) begin
                        r_d.scl = 1'b0;
                        r_d.sda = 1'b0;
                    end else begin
                        r_d.scl = 1'b1;
                    end
                end
            endcase
            r_d.st = tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, ucnt: '0, scl: 1'b0, sda: 1'b0, done: 1'b0,
                     rx: 1'b0, hs: 1'b0, rd: 1'b0, wbit: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_hs   = r_q.hs;
    assign cmd_ready = (r_q.st == S_IDLE);
    assign done      = r_q.done;
    assign rx_bit    = r_q.rx;
    assign scl_oe    = r_q.scl;
    assign sda_oe    = r_q.sda;

    // R10: completion lasts exactly one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an accepted primitive makes the engine busy
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_op <= OP_READ) |=> !cmd_ready);

    // R9: the latched set select never moves while busy
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> (busy_hs == $past(busy_hs)));

    // R8: a stretched SCL freezes the phase and its unit count
    a_r8_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (r_q.st == $past(r_q.st) && r_q.ucnt == $past(r_q.ucnt)));

    // R5: SDA stays put during the second part of the high phase
    a_r5_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_HIB) |-> $stable(sda_oe));

    // R7: a finished STOP leaves both lines released
    a_r7_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(r_q.st == S_PSU)) |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_mode,
    input  logic [WORD_W-1:0] fs_tim1,
    input  logic [WORD_W-1:0] fs_tim2,
    input  logic [WORD_W-1:0] fs_tim3,
    input  logic [WORD_W-1:0] hs_tim1,
    input  logic [WORD_W-1:0] hs_tim2,
    input  logic [WORD_W-1:0] hs_tim3,
    input  logic [WORD_W-1:0] hold_tim,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_bit,
    output logic              cmd_ready,
    output logic              done,
    output logic              rx_bit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);

    tset_t tim;
    logic  sel_hs;
    logic  busy_hs;
    logic  load;
    logic  tick;

    assign sel_hs = cmd_ready ? hs_mode : busy_hs;

    i2c_bt_setsel #(.NSETS(2)) u_sel (
        .sel_hs (sel_hs),
        .fs_w1  (fs_tim1),
        .fs_w2  (fs_tim2),
        .fs_w3  (fs_tim3),
        .hs_w1  (hs_tim1),
        .hs_w2  (hs_tim2),
        .hs_w3  (hs_tim3),
        .hold_w (hold_tim),
        .tim    (tim)
    );

    i2c_bt_tick #(.PW(FIELD_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .presc (tim.presc),
        .tick  (tick)
    );

    i2c_bt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tim       (tim),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .cmd_hs    (hs_mode),
        .tick      (tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .load      (load),
        .busy_hs   (busy_hs),
        .cmd_ready (cmd_ready),
        .done      (done),
        .rx_bit    (rx_bit),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

endmodule

// File: tb/tb_i2c_bit_timer.sv
module tb_i2c_bit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_mode = 1'b0;
    logic [31:0] fs_tim1, fs_tim2, fs_tim3, hs_tim1, hs_tim2, hs_tim3, hold_tim;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_bit = 1'b0;
    logic        cmd_ready, done, rx_bit, scl_oe, sda_oe;
    logic        scl_in, sda_in;
    logic        dev_sda = 1'b1;
    int          str_cnt = 0;
    int          str_req = 0;
    logic        str_load = 1'b0;

    int checks = 0;
    int errors = 0;
    bit run = 0;
    bit cur_scl = 0;
    bit cur_sda = 0;

    int ssu[2], shd[2], ssp[2], dsu[2], lo[2], hi[2], pr[2], sr[2];
    int hd;

    typedef struct {
        bit    scl;
        bit    sda;
        bit    dn;
        bit    rdy;
        bit    crx;
        bit    rx;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    assign scl_in = ~scl_oe & (str_cnt == 0);
    assign sda_in = ~sda_oe & dev_sda;

    // external device stretching SCL after the engine releases it
    always @(posedge clk) begin
        if (str_load) str_cnt <= str_req;
        else if (str_cnt > 0 && !scl_oe) str_cnt <= str_cnt - 1;
    end

    i2c_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
        .fs_tim1(fs_tim1), .fs_tim2(fs_tim2), .fs_tim3(fs_tim3),
        .hs_tim1(hs_tim1), .hs_tim2(hs_tim2), .hs_tim3(hs_tim3),
        .hold_tim(hold_tim), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_ready(cmd_ready), .done(done), .rx_bit(rx_bit),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(logic act, bit exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int ul(int n, int m);
        return ((n == 0) ? 1 : n) * (pr[m] + 1);
    endfunction

    task automatic ph(bit s, bit d, int n, string tag);
        exp_t e;
        e.scl = s; e.sda = d; e.dn = 0; e.rdy = 0; e.crx = 0; e.rx = 0; e.tag = tag;
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic fin(bit s, bit d, bit crx, bit rx, string tag);
        exp_t e;
        e.scl = s; e.sda = d; e.dn = 1; e.rdy = 1; e.crx = crx; e.rx = rx; e.tag = tag;
        q.push_back(e);
        cur_scl = s;
        cur_sda = d;
    endtask

    task automatic apply_cfg();
        fs_tim1  = {8'(ssu[0]), 8'(shd[0]), 8'(ssp[0]), 8'h00};
        fs_tim2  = {8'(dsu[0]), 8'h00, 8'(lo[0]), 8'(hi[0])};
        fs_tim3  = {8'h00, 8'(pr[0]), 8'h00, 8'(sr[0])};
        hs_tim1  = {8'(ssu[1]), 8'(shd[1]), 8'(ssp[1]), 8'h00};
        hs_tim2  = {8'(dsu[1]), 8'h00, 8'(lo[1]), 8'(hi[1])};
        hs_tim3  = {8'h00, 8'(pr[1]), 8'h00, 8'(sr[1])};
        hold_tim = {24'h0, 8'(hd)};
    endtask

    // issue one primitive and push its expected per-cycle waveform
    task automatic prim(logic [2:0] op, bit b, int m, int k, bit dev, bit holdv, string tag);
        bit nd;
        @(negedge clk);
        hs_mode = m[0]; cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
        str_req = k; str_load = 1'b1; dev_sda = dev;
        case (op)
            3'd0: begin
                ph(0, 0, ul(ssu[m], m), tag);
                ph(0, 1, ul(shd[m], m), tag);
                fin(1, 1, 0, 0, tag);
            end
            3'd1: begin
                ph(1, 0, ul(sr[m], m), tag);
                ph(0, 0, ul(ssu[m], m) + k, tag);
                ph(0, 1, ul(shd[m], m), tag);
                fin(1, 1, 0, 0, tag);
            end
            3'd2: begin
                ph(1, cur_sda, ul(hd, m), tag);
                ph(1, 1, ul(dsu[m], m), tag);
                ph(0, 1, ul(ssp[m], m) + k, tag);
                fin(0, 0, 0, 0, tag);
            end
            3'd3, 3'd4: begin
                nd = (op == 3'd4) ? 1'b0 : !b;
                ph(1, cur_sda, ul(hd, m), tag);
                ph(1, nd, ul(lo[m], m), tag);
                ph(0, nd, ul(hi[m] / 2, m) + k, tag);
                ph(0, nd, ul(hi[m] - hi[m] / 2, m), tag);
                fin(1, nd, op == 3'd4, dev, tag);
            end
            default: ;
        endcase
        @(negedge clk);
        str_load = 1'b0;
        if (holdv) begin
            cmd_op = 3'd2;
            repeat (3) @(negedge clk);
        end
        cmd_valid = 1'b0;
        hs_mode = !m[0];
        while (q.size() != 0) @(negedge clk);
    endtask

    // per-cycle comparison against the reference queue
    always begin
        @(posedge clk);
        #4;
        if (run) begin
            exp_t e;
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e.scl = cur_scl; e.sda = cur_sda; e.dn = 0; e.rdy = 1;
                e.crx = 0; e.rx = 0; e.tag = "R10";
            end
            chk(scl_oe, e.scl, e.tag, "scl_oe");
            chk(sda_oe, e.sda, e.tag, "sda_oe");
            chk(done, e.dn, e.tag, "done");
            chk(cmd_ready, e.rdy, e.tag, "cmd_ready");
            if (e.crx) chk(rx_bit, e.rx, e.tag, "rx_bit");
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        ssu = '{3, 2}; shd = '{2, 1}; ssp = '{3, 2}; dsu = '{1, 2};
        lo  = '{4, 2}; hi  = '{3, 2}; pr  = '{1, 0}; sr  = '{2, 1};
        hd  = 1;
        apply_cfg();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(scl_oe, 0, "R1", "scl_oe");
        chk(sda_oe, 0, "R1", "sda_oe");
        chk(cmd_ready, 1, "R1", "cmd_ready");
        chk(done, 0, "R1", "done");
        chk(rx_bit, 0, "R1", "rx_bit");
        rst_n = 1'b1;
        @(negedge clk);
        run = 1;
        repeat (3) @(negedge clk);

        // standard/fast set
        prim(3'd0, 0, 0, 0, 1, 0, "R3");
        prim(3'd3, 1, 0, 0, 1, 0, "R5");
        prim(3'd3, 0, 0, 0, 1, 0, "R5");
        prim(3'd4, 0, 0, 0, 1, 0, "R6");
        prim(3'd4, 0, 0, 0, 0, 0, "R6");
        prim(3'd1, 0, 0, 0, 1, 0, "R4");
        prim(3'd3, 1, 0, 5, 1, 0, "R8");
        prim(3'd7, 0, 0, 0, 1, 0, "R11");
        repeat (4) @(negedge clk);
        prim(3'd2, 0, 0, 0, 1, 0, "R7");
        prim(3'd5, 0, 0, 0, 1, 0, "R11");
        repeat (4) @(negedge clk);

        // high-speed set, mode input flipped after acceptance
        prim(3'd0, 0, 1, 0, 1, 0, "R9");
        prim(3'd4, 0, 1, 3, 1, 0, "R8");
        prim(3'd4, 0, 1, 0, 0, 0, "R9");
        prim(3'd1, 0, 1, 2, 1, 0, "R4");
        prim(3'd3, 0, 1, 0, 1, 0, "R9");
        prim(3'd2, 0, 1, 4, 1, 0, "R8");

        // larger prescaler and zero / one unit counts
        pr[0] = 3; lo[0] = 0; hi[0] = 1; ssu[0] = 0; sr[0] = 1;
        apply_cfg();
        prim(3'd0, 0, 0, 0, 1, 0, "R2");
        prim(3'd3, 0, 0, 0, 1, 0, "R2");
        prim(3'd4, 0, 0, 0, 1, 0, "R6");
        prim(3'd1, 0, 0, 0, 1, 0, "R2");

        // request held high while busy
        prim(3'd3, 1, 0, 0, 1, 1, "R10");
        prim(3'd2, 0, 0, 0, 1, 1, "R10");
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule